// File: doc/BRIEF.md
# Strided Vector Load Bank Controller

This block carries out one vector load against a memory split into interleaved banks. Software-visible control is reduced to a start pulse carrying a base word address, a stride and an element count. The controller walks the elements in index order and computes each element's word address. It picks the bank from the low address bits and holds back any element whose bank is still recovering from an earlier access. Each load is delivered to a vector register write port a fixed number of cycles after its request was issued.

At most one element request leaves per cycle. The memory is read in the request cycle, and the returned word travels down a fixed-length delay line that models the access latency. Writes therefore come out in the same order the requests went in. When the last element is written, a one-cycle completion pulse is raised. At that point a cycle counter shows how many cycles the load took, counted from the start cycle. With no conflicts, a 64-element load takes 12 + 64 = 76 cycles. If every access lands in the same bank, it takes 12 + 1 + 6×63 = 391 cycles.

The controller is a four-state machine:
- `ST_IDLE` waits for a start.
- `ST_ISSUE` sends element requests and stalls on busy banks.
- `ST_DRAIN` waits for the outstanding returns.
- `ST_EMPTY` completes a zero-length load.

The transitions are:
- IDLE→ISSUE on a start with a non-zero count.
- IDLE→EMPTY on a start with a zero count.
- ISSUE→DRAIN when the last element is issued.
- DRAIN→IDLE when the last element is written.
- EMPTY→IDLE unconditionally.

Top module: `strided_load_bank_ctrl`

## Requirements
- R1: Element i is requested at word address (base + i×stride) modulo 2^ADDR_W, with at most one request per cycle, in increasing element order. A stride of all ones therefore walks addresses downward.
- R2: The bank of every request equals its word address modulo 8, i.e. the low three address bits, and the memory is read from that bank.
- R3: A bank that accepts a request in cycle t accepts no further request before cycle t+6. A request for a busy bank stalls, and the elements behind it wait.
- R4: The write for an element appears exactly 12 cycles after its request cycle and carries the memory word read at that element's address.
- R5: Element writes come out once each, with indices 0, 1, …, n−1 in that order and no gaps.
- R6: In the cycle of the completion pulse, the cycle counter equals the number of cycles since the start cycle. It then holds that value until the next start. A 64-element load with unit stride reads 76; one whose stride is a multiple of 8 reads 391.
- R7: The completion pulse lasts exactly one cycle and coincides with the write of the last element. The busy output is high from the cycle after the start until and including that cycle.
- R8: A start with count 0 issues no request and no write, and completes in the next cycle with a counter value of 1. A count above 64 is treated as 64.
- R9: A start asserted while a load is in progress is ignored: the running load's requests, writes and completion are unchanged, and no second load follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a load (taken only when idle) |
| base_i | input | ADDR_W | Word address of element 0 |
| stride_i | input | ADDR_W | Word distance between elements (modular) |
| vlen_i | input | VLEN_W | Element count, 0 to 64 (larger values clamp) |
| busy_o | output | 1 | A load is in progress |
| mem_req_o | output | 1 | Element request issued this cycle |
| mem_addr_o | output | ADDR_W | Word address of the request |
| mem_bank_o | output | BANK_W | Bank selected for the request |
| mem_rdata_i | input | DATA_W | Word read from the addressed bank in the request cycle |
| vrf_we_o | output | 1 | Vector register write enable |
| vrf_idx_o | output | IDX_W | Element index of the write |
| vrf_data_o | output | DATA_W | Element data written |
| done_o | output | 1 | One-cycle completion pulse |
| cycles_o | output | CNT_W | Cycles since the start of the current or last load |

## Verification
Some properties are watched on every cycle. These are:
- the address step between consecutive requests;
- the six-cycle rest of each bank;
- the strict 0, 1, 2… order of writes;
- the single-cycle completion pulse and its overlap with busy;
- the counter advancing by one per busy cycle;
- a start during a load never dropping busy.

Other behaviour only shows up in the bench scenarios. The exact stall pattern, and therefore the total cycle count for each stride, is one of them. Others are the returned data and the 12-cycle request-to-write distance per element, the zero-length and clamped counts, and the absence of any trace of an ignored start.

// File: rtl/sld_pkg.sv
package sld_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2,
        ST_EMPTY = 2'd3
    } ld_state_e;

endpackage

// File: rtl/sld_addr_gen.sv
module sld_addr_gen #(
    parameter int ADDR_W  = 16,
    parameter int MAX_VL  = 64,
    parameter int BANK_W  = 3,
    parameter int IDX_W   = 6,
    parameter int VLEN_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] stride,
    input  logic [VLEN_W-1:0] vlen,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank,
    output logic [IDX_W-1:0]  idx,
    output logic              is_last
);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] stride_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  last_q;
    logic [VLEN_W-1:0] vlen_eff;
    logic [VLEN_W-1:0] vlen_m1;

    // Counts beyond the register length clamp to the maximum
    always_comb begin
        if (vlen > VLEN_W'(MAX_VL)) begin
            vlen_eff = VLEN_W'(MAX_VL);
        end else begin
            vlen_eff = vlen;
        end
        vlen_m1 = vlen_eff - VLEN_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            stride_q <= '0;
            idx_q    <= '0;
            last_q   <= '0;
        end else if (load) begin
            addr_q   <= base;
            stride_q <= stride;
            idx_q    <= '0;
            last_q   <= vlen_m1[IDX_W-1:0];
        end else if (advance) begin
            addr_q   <= addr_q + stride_q;
            idx_q    <= idx_q + IDX_W'(1);
        end
    end

    assign addr    = addr_q;
    assign bank    = addr_q[BANK_W-1:0];
    assign idx     = idx_q;
    assign is_last = (idx_q == last_q);

endmodule

// File: rtl/sld_bank_timers.sv
module sld_bank_timers #(
    parameter int NUM_BANKS = 8,
    parameter int BANK_W    = 3,
    parameter int BUSY_CYC  = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue,
    input  logic [BANK_W-1:0]    issue_bank,
    output logic [NUM_BANKS-1:0] bank_free
);

    localparam int TMR_W = $clog2(BUSY_CYC + 1);
    localparam logic [TMR_W-1:0] RELOAD = TMR_W'(BUSY_CYC - 1);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [TMR_W-1:0] tmr_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tmr_q <= '0;
            end else if (issue && (issue_bank == BANK_W'(b))) begin
                tmr_q <= RELOAD;
            end else if (tmr_q != '0) begin
                tmr_q <= tmr_q - TMR_W'(1);
            end
        end

        assign bank_free[b] = (tmr_q == '0);
    end

endmodule

// File: rtl/sld_return_pipe.sv
module sld_return_pipe #(
    parameter int LAT    = 12,
    parameter int DATA_W = 64,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [IDX_W-1:0]  in_idx,
    input  logic              in_last,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [IDX_W-1:0]  out_idx,
    output logic              out_last,
    output logic [DATA_W-1:0] out_data
);

    logic [LAT-1:0]    vld_q;
    logic [LAT-1:0]    lst_q;
    logic [IDX_W-1:0]  idx_q [LAT];
    logic [DATA_W-1:0] dat_q [LAT];

    for (genvar s = 0; s < LAT; s++) begin : g_stage
        if (s == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld_q[s] <= 1'b0;
                    lst_q[s] <= 1'b0;
                    idx_q[s] <= '0;
                    dat_q[s] <= '0;
                end else begin
                    vld_q[s] <= in_valid;
                    lst_q[s] <= in_last & in_valid;
                    idx_q[s] <= in_idx;
                    dat_q[s] <= in_data;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld_q[s] <= 1'b0;
                    lst_q[s] <= 1'b0;
                    idx_q[s] <= '0;
                    dat_q[s] <= '0;
                end else begin
                    vld_q[s] <= vld_q[s-1];
                    lst_q[s] <= lst_q[s-1];
                    idx_q[s] <= idx_q[s-1];
                    dat_q[s] <= dat_q[s-1];
                end
            end
        end
    end

    assign out_valid = vld_q[LAT-1];
    assign out_last  = lst_q[LAT-1];
    assign out_idx   = idx_q[LAT-1];
    assign out_data  = dat_q[LAT-1];

endmodule

// File: rtl/strided_load_bank_ctrl.sv
module strided_load_bank_ctrl
    import sld_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int BUSY_CYC  = 6,
    parameter int MEM_LAT   = 12,
    parameter int MAX_VL    = 64,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 64,
    parameter int CNT_W     = 16,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int IDX_W    = $clog2(MAX_VL),
    localparam int VLEN_W   = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  logic [VLEN_W-1:0] vlen_i,
    output logic              busy_o,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [BANK_W-1:0] mem_bank_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              vrf_we_o,
    output logic [IDX_W-1:0]  vrf_idx_o,
    output logic [DATA_W-1:0] vrf_data_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  cycles_o
);

    ld_state_e state_q;
    ld_state_e state_d;

    logic                 accept;
    logic                 issue;
    logic                 finish;
    logic [ADDR_W-1:0]    cur_addr;
    logic [BANK_W-1:0]    cur_bank;
    logic [IDX_W-1:0]     cur_idx;
    logic                 cur_last;
    logic [NUM_BANKS-1:0] bank_free;
    logic                 ret_valid;
    logic                 ret_last;
    logic [IDX_W-1:0]     ret_idx;
    logic [DATA_W-1:0]    ret_data;
    logic [CNT_W-1:0]     cnt_q;

    assign accept = start_i && (state_q == ST_IDLE);

    sld_addr_gen #(
        .ADDR_W (ADDR_W),
        .MAX_VL (MAX_VL),
        .BANK_W (BANK_W),
        .IDX_W  (IDX_W),
        .VLEN_W (VLEN_W)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .base    (base_i),
        .stride  (stride_i),
        .vlen    (vlen_i),
        .advance (issue),
        .addr    (cur_addr),
        .bank    (cur_bank),
        .idx     (cur_idx),
        .is_last (cur_last)
    );

    sld_bank_timers #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W),
        .BUSY_CYC  (BUSY_CYC)
    ) u_timers (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (issue),
        .issue_bank (cur_bank),
        .bank_free  (bank_free)
    );

    sld_return_pipe #(
        .LAT    (MEM_LAT),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_ret (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (issue),
        .in_idx    (cur_idx),
        .in_last   (cur_last),
        .in_data   (mem_rdata_i),
        .out_valid (ret_valid),
        .out_idx   (ret_idx),
        .out_last  (ret_last),
        .out_data  (ret_data)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = (vlen_i == '0) ? ST_EMPTY : ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (issue && cur_last) begin
                    state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (ret_valid && ret_last) begin
                    state_d = ST_IDLE;
                end
            end
            ST_EMPTY: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        issue  = 1'b0;
        finish = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ISSUE: issue  = bank_free[cur_bank];
            ST_DRAIN: finish = ret_valid && ret_last;
            ST_EMPTY: finish = 1'b1;
            default:  ;
        endcase
    end

    // Cycle counter: 1 in the first cycle after start, frozen after completion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (accept) begin
            cnt_q <= CNT_W'(1);
        end else if ((state_q != ST_IDLE) && !finish) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign busy_o     = (state_q != ST_IDLE);
    assign mem_req_o  = issue;
    assign mem_addr_o = cur_addr;
    assign mem_bank_o = cur_bank;
    assign vrf_we_o   = ret_valid;
    assign vrf_idx_o  = ret_idx;
    assign vrf_data_o = ret_data;
    assign done_o     = finish;
    assign cycles_o   = cnt_q;

endmodule

// File: rtl/sld_bank_ctrl_chk.sv
module sld_bank_ctrl_chk #(
    parameter int NUM_BANKS = 8,
    parameter int BUSY_CYC  = 6,
    parameter int MAX_VL    = 64,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 64,
    parameter int CNT_W     = 16,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int IDX_W    = $clog2(MAX_VL),
    localparam int VLEN_W   = $clog2(MAX_VL + 1),
    localparam int GAP_W    = $clog2(BUSY_CYC + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [ADDR_W-1:0] base_i,
    input logic [ADDR_W-1:0] stride_i,
    input logic [VLEN_W-1:0] vlen_i,
    input logic              busy_o,
    input logic              mem_req_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [BANK_W-1:0] mem_bank_o,
    input logic [DATA_W-1:0] mem_rdata_i,
    input logic              vrf_we_o,
    input logic [IDX_W-1:0]  vrf_idx_o,
    input logic [DATA_W-1:0] vrf_data_o,
    input logic              done_o,
    input logic [CNT_W-1:0]  cycles_o
);

    logic              taken;
    logic [ADDR_W-1:0] stride_l;
    logic [ADDR_W-1:0] prev_addr;
    logic              req_seen;
    logic              wr_seen;
    logic [IDX_W-1:0]  last_wr;
    logic [GAP_W-1:0]  gap [NUM_BANKS];

    assign taken = start_i && !busy_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stride_l  <= '0;
            prev_addr <= '0;
            req_seen  <= 1'b0;
            wr_seen   <= 1'b0;
            last_wr   <= '0;
        end else begin
            if (taken) begin
                stride_l <= stride_i;
                req_seen <= 1'b0;
                wr_seen  <= 1'b0;
            end
            if (mem_req_o) begin
                prev_addr <= mem_addr_o;
                req_seen  <= 1'b1;
            end
            if (vrf_we_o) begin
                last_wr <= vrf_idx_o;
                wr_seen <= 1'b1;
            end
        end
    end

    // Cycles since each bank last saw a request, saturating at the busy time
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NUM_BANKS; b++) gap[b] <= GAP_W'(BUSY_CYC);
        end else begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (mem_req_o && (mem_bank_o == BANK_W'(b))) begin
                    gap[b] <= GAP_W'(1);
                end else if (gap[b] != GAP_W'(BUSY_CYC)) begin
                    gap[b] <= gap[b] + GAP_W'(1);
                end
            end
        end
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && req_seen) |-> (mem_addr_o == prev_addr + stride_l)); // R1

    AST_BANK_REST: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (gap[mem_bank_o] == GAP_W'(BUSY_CYC))); // R3

    AST_FIRST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (vrf_we_o && !wr_seen) |-> (vrf_idx_o == '0)); // R5

    AST_WRITE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (vrf_we_o && wr_seen) |-> (vrf_idx_o == last_wr + IDX_W'(1))); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7

    AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o); // R7

    AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> (cycles_o == $past(cycles_o) + CNT_W'(1))); // R6

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && start_i) |=> busy_o); // R9

endmodule

bind strided_load_bank_ctrl sld_bank_ctrl_chk #(
    .NUM_BANKS (NUM_BANKS),
    .BUSY_CYC  (BUSY_CYC),
    .MAX_VL    (MAX_VL),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CNT_W     (CNT_W)
) u_chk (.*);

// File: tb/strided_load_bank_ctrl_tb.sv
`timescale 1ns/1ps
module strided_load_bank_ctrl_tb;

    localparam int AW  = 10;
    localparam int DW  = 32;
    localparam int CW  = 16;
    localparam int LAT = 12;
    localparam int RST = 6;

    typedef struct packed {
        logic [9:0]  base;
        logic [9:0]  stride;
        logic [6:0]  vlen;
        logic [15:0] cyc;
    } vec_t;

    // base, stride, count, expected cycles
    localparam vec_t VEC [8] = '{
        '{10'd0,   10'd1,     7'd64, 16'd76},
        '{10'd5,   10'd8,     7'd64, 16'd391},
        '{10'd3,   10'd2,     7'd64, 16'd106},
        '{10'd0,   10'd4,     7'd64, 16'd200},
        '{10'd7,   10'd3,     7'd10, 16'd22},
        '{10'd0,   10'd16,    7'd5,  16'd37},
        '{10'd100, 10'h3FF,   7'd20, 16'd32},
        '{10'd9,   10'd0,     7'd3,  16'd25}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] base_i = '0;
    logic [AW-1:0] stride_i = '0;
    logic [6:0]    vlen_i = '0;
    logic          busy_o;
    logic          mem_req_o;
    logic [AW-1:0] mem_addr_o;
    logic [2:0]    mem_bank_o;
    logic [DW-1:0] mem_rdata_i;
    logic          vrf_we_o;
    logic [5:0]    vrf_idx_o;
    logic [DW-1:0] vrf_data_o;
    logic          done_o;
    logic [CW-1:0] cycles_o;

    always #5 clk = ~clk;

    strided_load_bank_ctrl #(
        .ADDR_W (AW),
        .DATA_W (DW),
        .CNT_W  (CW)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .base_i      (base_i),
        .stride_i    (stride_i),
        .vlen_i      (vlen_i),
        .busy_o      (busy_o),
        .mem_req_o   (mem_req_o),
        .mem_addr_o  (mem_addr_o),
        .mem_bank_o  (mem_bank_o),
        .mem_rdata_i (mem_rdata_i),
        .vrf_we_o    (vrf_we_o),
        .vrf_idx_o   (vrf_idx_o),
        .vrf_data_o  (vrf_data_o),
        .done_o      (done_o),
        .cycles_o    (cycles_o)
    );

    function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
        return {6'h2B, a, 6'h15, a};
    endfunction

    // Behavioural banked memory, read through the bank the design selects
    logic [DW-1:0] bank_mem [8][128];
    initial begin
        for (int a = 0; a < 1024; a++) bank_mem[a % 8][a / 8] = word_of(AW'(a));
    end
    assign mem_rdata_i = bank_mem[mem_bank_o][mem_addr_o[9:3]];

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int errors = 0;
    int checks = 0;

    // Monitor state
    int            n_req, wr_cnt, dn_cnt, done_cyc, done_val;
    int            order_bad, bank_bad, rest_bad;
    bit            done_seen;
    logic [AW-1:0] req_addr [64];
    int            req_cyc [64];
    int            wr_cyc [64];
    logic [DW-1:0] wr_data [64];
    int            last_bank [8];

    task automatic clear_mon();
        n_req = 0; wr_cnt = 0; dn_cnt = 0; done_cyc = 0; done_val = 0;
        order_bad = 0; bank_bad = 0; rest_bad = 0; done_seen = 1'b0;
        for (int b = 0; b < 8; b++) last_bank[b] = -100;
        for (int k = 0; k < 64; k++) begin
            req_cyc[k] = -1000; wr_cyc[k] = 0; wr_data[k] = '0; req_addr[k] = '0;
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req_o) begin
                if (n_req < 64) begin
                    req_addr[n_req] = mem_addr_o;
                    req_cyc[n_req] = cyc;
                end
                if (mem_bank_o != mem_addr_o[2:0]) bank_bad++;
                if (cyc - last_bank[mem_bank_o] < 6) rest_bad++;
                last_bank[mem_bank_o] = cyc;
                n_req++;
            end
            if (vrf_we_o) begin
                if (int'(vrf_idx_o) != wr_cnt) order_bad++;
                wr_cyc[vrf_idx_o] = cyc;
                wr_data[vrf_idx_o] = vrf_data_o;
                wr_cnt++;
            end
            if (done_o) begin
                dn_cnt++;
                done_cyc = cyc;
                done_val = int'(cycles_o);
                done_seen = 1'b1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_load(input logic [AW-1:0] b, input logic [AW-1:0] s,
                            input logic [6:0] vl, input int exp_cyc, input bit poke);
        int start_cyc;
        int n_exp;
        int waited;
        int addr_bad;
        int data_bad;
        int lat_bad;
        n_exp = (vl > 7'd64) ? 64 : int'(vl);
        @(negedge clk);
        clear_mon();
        base_i = b; stride_i = s; vlen_i = vl; start_i = 1'b1;
        start_cyc = cyc;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            base_i = 10'd500; stride_i = 10'd7; vlen_i = 7'd3; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        waited = 0;
        while (!done_seen && waited < 2000) begin
            @(posedge clk);
            waited++;
        end
        repeat (20) @(negedge clk);
        chk(dn_cnt == 1, "R7", "completion pulses", dn_cnt, 1);
        chk(done_val == exp_cyc, "R6", "cycle counter at completion", done_val, exp_cyc);
        chk(done_cyc - start_cyc == exp_cyc, "R7", "completion cycle after start",
            done_cyc - start_cyc, exp_cyc);
        chk(int'(cycles_o) == exp_cyc, "R6", "counter held after completion",
            int'(cycles_o), exp_cyc);
        chk(n_req == n_exp, "R1", "request count", n_req, n_exp);
        chk(wr_cnt == n_exp, "R5", "write count", wr_cnt, n_exp);
        chk(order_bad == 0, "R5", "out-of-order writes", order_bad, 0);
        chk(bank_bad == 0, "R2", "bank differs from address mod 8", bank_bad, 0);
        chk(rest_bad == 0, "R3", "bank reused within 6 cycles", rest_bad, 0);
        addr_bad = 0; data_bad = 0; lat_bad = 0;
        for (int k = 0; k < n_exp && k < 64; k++) begin
            logic [AW-1:0] ea;
            ea = b + AW'(k) * s;
            if (req_addr[k] != ea) addr_bad++;
            if (wr_data[k] != word_of(ea)) data_bad++;
            if (wr_cyc[k] - req_cyc[k] != LAT) lat_bad++;
        end
        chk(addr_bad == 0, "R1", "element addresses wrong", addr_bad, 0);
        chk(data_bad == 0, "R4", "element data wrong", data_bad, 0);
        chk(lat_bad == 0, "R4", "request-to-write distance not 12", lat_bad, 0);
        chk(busy_o == 1'b0, "R7", "busy after completion", int'(busy_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        clear_mon();
        repeat (RST) @(negedge clk);
        // Reset state
        chk(busy_o == 1'b0 && done_o == 1'b0, "R7", "busy/done in reset",
            int'({busy_o, done_o}), 0);
        chk(mem_req_o == 1'b0 && vrf_we_o == 1'b0, "R1", "request/write in reset",
            int'({mem_req_o, vrf_we_o}), 0);
        chk(cycles_o == '0, "R6", "counter in reset", int'(cycles_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy_o == 1'b0 && mem_req_o == 1'b0, "R7", "idle after reset",
            int'({busy_o, mem_req_o}), 0);

        // Vector table: stride patterns and expected cycle totals
        for (int v = 0; v < 8; v++) begin
            run_load(VEC[v].base, VEC[v].stride, VEC[v].vlen, int'(VEC[v].cyc), 1'b0);
        end

        // R8: zero-length load
        run_load(10'd40, 10'd1, 7'd0, 1, 1'b0);
        // R8: count above the maximum clamps to 64
        run_load(10'd10, 10'd1, 7'd100, 76, 1'b0);
        // R9: a start during a running load is ignored
        run_load(10'd20, 10'd1, 7'd8, 20, 1'b1);
        // R3: same-bank stride right after a load, back to back
        run_load(10'd2, 10'd24, 7'd4, 1 + 18 + LAT, 1'b0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule